// File: doc/BRIEF.md
# Parity-Width Bus Holding Latch

This block is a bank of level-sensitive D latches whose contents are placed on a shared bus through tri-state drivers. It suits wide address or data paths that also carry a parity bit. While the load strobe is high, the stored word tracks the input word. When the strobe falls, the word is frozen. The bus sees the stored word, or its complement, only while every one of the active-low output enables is low. Otherwise the block leaves the bus floating so that another master can drive it.

Parameters select the word width, the output polarity, whether the asynchronous set and clear inputs take effect, and whether there are one or three output enables. With three enables, each one can belong to a different agent, such as a chip select, a DMA grant or a read strobe. The bus is driven only when all of them agree.

Top module: `bus_hold_latch`

## Requirements
- R1: While `le` is 1 and neither set nor clear is active, the stored word equals `d_in` with no clock involved. An enabled bus shows it directly when `INVERT` is 0.
- R2: When `le` falls, the word present on `d_in` is kept. Later changes of `d_in` while `le` stays 0 do not reach the bus.
- R3: With one enable, the bus is driven when `oe_n` is 0 and released (high-impedance) when `oe_n` is 1.
- R4: With three enables, the bus is driven only when `oe_n` equals 3'b000. Any of the seven other codes releases it.
- R5: While `clr_n` is 0 and `set_n` is 1, the stored word is all zeros, whatever the value of `le`.
- R6: While `set_n` is 0, the stored word is all ones, even when `clr_n` is 0 as well.
- R7: While `clr_n` is 0, `d_in` cannot enter the store, even when `le` is 1.
- R8: When set or clear is released while `le` is 0, the forced value stays in the store.
- R9: With `INVERT` set to 1, the bus carries the bitwise complement of the store. A set therefore drives all zeros and a clear drives all ones.
- R10: With `HAS_SETCLR` set to 0, `clr_n` and `set_n` have no effect on the store.
- R11: Changing the output enables never alters the stored word. This holds even when `d_in` changes while the bus is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| d_in | input | WIDTH | Word to be captured |
| le | input | 1 | Load strobe: transparent while 1, holds while 0 |
| clr_n | input | 1 | Asynchronous clear, active low (used when HAS_SETCLR=1) |
| set_n | input | 1 | Asynchronous set, active low, overrides clear (used when HAS_SETCLR=1) |
| oe_n | input | NUM_OE | Output enables, all active low; the bus is driven only when all are 0 |
| q_bus | output | WIDTH | Tri-state bus output |

## Verification
The bench builds three copies of the block.

- The first is 8 bits wide, non-inverting, with set, clear and three enables. It gives exhaustive coverage of all eight enable codes and of every 8-bit data value in transparent mode.
- The second is 9 bits wide, inverting, with set and clear and one enable. It shows the polarity swap of set and clear on the bus.
- The third is 10 bits wide, non-inverting, with no set or clear. It shows that the set and clear inputs are ignored while the other copies are being forced.

A released bus is detected because the bench then drives its own pattern onto the shared net and reads that pattern back.

// File: rtl/bus_hold_latch.sv
module bus_hold_latch #(
  parameter int WIDTH      = 9,
  parameter int NUM_OE     = 1,
  parameter bit INVERT     = 1'b0,
  parameter bit HAS_SETCLR = 1'b1
) (
  input  logic [WIDTH-1:0]  d_in,
  input  logic              le,
  input  logic              clr_n,
  input  logic              set_n,
  input  logic [NUM_OE-1:0] oe_n,
  output logic [WIDTH-1:0]  q_bus
);

  localparam logic [WIDTH-1:0] POL = {WIDTH{INVERT}};

  if (NUM_OE != 1 && NUM_OE != 3) begin : g_bad_oe
    $error("NUM_OE must be 1 or 3");
  end

  logic             set_act;
  logic             clr_act;
  logic             drive;
  logic [WIDTH-1:0] store;
  logic [WIDTH-1:0] q_drv;

  assign set_act = HAS_SETCLR & ~set_n;
  assign clr_act = HAS_SETCLR & ~clr_n;
  assign drive   = ~|oe_n;

  always_latch begin
    if (set_act)      store = '1;
    else if (clr_act) store = '0;
    else if (le)      store = d_in;
  end

  assign q_drv = store ^ POL;
  assign q_bus = drive ? q_drv : 'z;

  always_comb begin
    if (drive && le && !set_act && !clr_act) begin
      AST_TRANSPARENT: assert (q_drv == (d_in ^ POL)); // R1
    end
    if (drive && set_act) begin
      AST_SET_WINS: assert (q_drv == ~POL); // R6
    end
    if (drive && clr_act && !set_act) begin
      AST_CLEAR_ZERO: assert (q_drv == POL); // R5
    end
    if (!HAS_SETCLR && drive && le) begin
      AST_NO_SETCLR: assert (q_drv == (d_in ^ POL)); // R10
    end
  end

endmodule

// File: tb/bus_hold_latch_test.sv
module bus_hold_latch_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [9:0] d;
  logic       le, mr_n, pr_n, oe1;
  logic [2:0] oe3;
  logic       rel_a, rel_bc;
  logic [9:0] pat;
  wire  [7:0] bus_a;
  wire  [8:0] bus_b;
  wire  [9:0] bus_c;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  assign bus_a = rel_a  ? pat[7:0] : 'z;
  assign bus_b = rel_bc ? pat[8:0] : 'z;
  assign bus_c = rel_bc ? pat      : 'z;

  bus_hold_latch #(.WIDTH(8), .NUM_OE(3), .INVERT(1'b0), .HAS_SETCLR(1'b1)) uut (
    .d_in(d[7:0]), .le(le), .clr_n(mr_n), .set_n(pr_n), .oe_n(oe3), .q_bus(bus_a));
  bus_hold_latch #(.WIDTH(9), .NUM_OE(1), .INVERT(1'b1), .HAS_SETCLR(1'b1)) uut_inv (
    .d_in(d[8:0]), .le(le), .clr_n(mr_n), .set_n(pr_n), .oe_n(oe1), .q_bus(bus_b));
  bus_hold_latch #(.WIDTH(10), .NUM_OE(1), .INVERT(1'b0), .HAS_SETCLR(1'b0)) uut_bare (
    .d_in(d), .le(le), .clr_n(mr_n), .set_n(pr_n), .oe_n(oe1), .q_bus(bus_c));

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [9:0] dv, input logic lv, input logic mv, input logic pv,
                       input logic [2:0] o3, input logic o1, input logic [9:0] pv_pat);
    @(negedge clk);
    d = dv; le = lv; mr_n = mv; pr_n = pv; oe3 = o3; oe1 = o1; pat = pv_pat;
    rel_a = (o3 != 3'b000);
    rel_bc = o1;
    @(posedge clk);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    d = '0; le = 1'b0; mr_n = 1'b1; pr_n = 1'b1; oe3 = 3'b111; oe1 = 1'b1;
    rel_a = 1'b1; rel_bc = 1'b1; pat = '0;
    // reset state: clear asserted
    apply(10'h000, 1'b0, 1'b0, 1'b1, 3'b000, 1'b0, 10'h0);
    chk("R5 reset state", {2'b0, bus_a}, 10'h000);
    chk("R9 reset state inverted", {1'b0, bus_b}, 10'h1FF);
    // R1 exhaustive transparent sweep
    for (int v = 0; v < 256; v++) begin
      logic [9:0] dv;
      dv = 10'((v * 37 + 5) & 10'h3FF);
      dv[7:0] = 8'(v);
      apply(dv, 1'b1, 1'b1, 1'b1, 3'b000, 1'b0, 10'h0);
      chk("R1 transparent", {2'b0, bus_a}, {2'b0, dv[7:0]});
      chk("R9 transparent inverted", {1'b0, bus_b}, {1'b0, ~dv[8:0]});
      chk("R1 transparent wide", bus_c, dv);
    end
    // R2 capture
    apply(10'h2B6, 1'b1, 1'b1, 1'b1, 3'b000, 1'b0, 10'h0);
    apply(10'h2B6, 1'b0, 1'b1, 1'b1, 3'b000, 1'b0, 10'h0);
    apply(10'h149, 1'b0, 1'b1, 1'b1, 3'b000, 1'b0, 10'h0);
    chk("R2 hold", {2'b0, bus_a}, 10'h0B6);
    chk("R2 hold inverted", {1'b0, bus_b}, 10'h149);
    chk("R2 hold wide", bus_c, 10'h2B6);
    apply(10'h149, 1'b1, 1'b1, 1'b1, 3'b000, 1'b0, 10'h0);
    chk("R1 reopen", bus_c, 10'h149);
    // R3 / R4 / R11 enables
    apply(10'h15A, 1'b1, 1'b1, 1'b1, 3'b000, 1'b0, 10'h0);
    apply(10'h15A, 1'b0, 1'b1, 1'b1, 3'b000, 1'b0, 10'h0);
    for (int c = 0; c < 8; c++) begin
      logic [9:0] p;
      p = 10'h3C3 ^ 10'(c);
      apply(10'h15A, 1'b0, 1'b1, 1'b1, 3'(c), c[0], p);
      chk("R4 three enables", {2'b0, bus_a}, (c == 0) ? 10'h05A : {2'b0, p[7:0]});
      chk("R3 single enable", bus_c, c[0] ? p : 10'h15A);
      chk("R3 single enable inverted", {1'b0, bus_b}, c[0] ? {1'b0, p[8:0]} : 10'h0A5);
    end
    apply(10'h0E1, 1'b0, 1'b1, 1'b1, 3'b101, 1'b1, 10'h2AA);
    apply(10'h0E1, 1'b0, 1'b1, 1'b1, 3'b000, 1'b0, 10'h0);
    chk("R11 store kept across enables", {2'b0, bus_a}, 10'h05A);
    chk("R11 store kept wide", bus_c, 10'h15A);
    // R5 / R7 / R8 / R10 clear
    apply(10'h0E1, 1'b0, 1'b0, 1'b1, 3'b000, 1'b0, 10'h0);
    chk("R5 clear", {2'b0, bus_a}, 10'h000);
    chk("R9 clear inverted", {1'b0, bus_b}, 10'h1FF);
    chk("R10 clear ignored", bus_c, 10'h15A);
    apply(10'h0F0, 1'b1, 1'b0, 1'b1, 3'b000, 1'b0, 10'h0);
    chk("R7 clear blocks entry", {2'b0, bus_a}, 10'h000);
    chk("R7 clear blocks entry inverted", {1'b0, bus_b}, 10'h1FF);
    chk("R10 transparent under clear", bus_c, 10'h0F0);
    apply(10'h0F0, 1'b0, 1'b0, 1'b1, 3'b000, 1'b0, 10'h0);
    apply(10'h0F0, 1'b0, 1'b1, 1'b1, 3'b000, 1'b0, 10'h0);
    chk("R8 clear retained", {2'b0, bus_a}, 10'h000);
    chk("R8 clear retained inverted", {1'b0, bus_b}, 10'h1FF);
    // R6 / R8 / R9 / R10 set
    apply(10'h0F0, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 10'h0);
    chk("R6 set beats clear", {2'b0, bus_a}, 10'h0FF);
    chk("R9 set inverted", {1'b0, bus_b}, 10'h000);
    chk("R10 set ignored", bus_c, 10'h0F0);
    apply(10'h033, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0, 10'h0);
    chk("R6 set over transparency", {2'b0, bus_a}, 10'h0FF);
    chk("R10 transparent under set", bus_c, 10'h033);
    apply(10'h033, 1'b0, 1'b1, 1'b0, 3'b000, 1'b0, 10'h0);
    apply(10'h033, 1'b0, 1'b1, 1'b1, 3'b000, 1'b0, 10'h0);
    apply(10'h2CC, 1'b0, 1'b1, 1'b1, 3'b000, 1'b0, 10'h0);
    chk("R8 set retained", {2'b0, bus_a}, 10'h0FF);
    chk("R8 set retained inverted", {1'b0, bus_b}, 10'h000);
    chk("R2 hold wide after set", bus_c, 10'h033);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule